// File: doc/BRIEF.md
# Bidirectional Handshake Parallel Port

This block is one parallel port that carries data both ways over a single set of shared data pins. It has two holding registers. The receive register takes the pin data while the attached device holds its strobe low. The transmit register is loaded by the CPU, and it drives the pins only while the device holds its acknowledge low. At all other times the pins are released. The tri-state pad is shown as a per-bit output enable next to the output data.

Each direction has its own buffer-full flag. The receive flag is high-true and the transmit flag is low-true. Both directions share one interrupt request. Software enables the interrupt for each direction with a bit set/reset command.

Both handshakes run at the same time. A device may strobe new data in while the transmit register is still waiting for its acknowledge. Neither handshake disturbs the other direction's register.

Top module: `bidir_hs_port`

## Requirements
- R1: After reset, rxFull is 0, txEmptyN is 1, irq is 0, and both interrupt enables are 0. With ackN high, every bit of padOe is 0.
- R2: A clock edge that sees stbN low loads padIn into the receive register and sets rxFull. The new data appears on cpuRdData after that edge.
- R3: A clock edge that sees cpuRdEn high with stbN high clears rxFull. When cpuRdEn and a low stbN meet on the same edge, the strobe wins and rxFull stays 1.
- R4: A clock edge that sees cpuWrEn high loads cpuWrData into the transmit register and drives txEmptyN to 0.
- R5: A clock edge that sees ackN low drives txEmptyN to 1. When ackN is low and cpuWrEn is high on the same edge, the write wins and txEmptyN is 0.
- R6: padOe has all bits 1 while ackN is low and all bits 0 while ackN is high, with no clock delay. padOut always shows the transmit register.
- R7: A CPU read changes neither the transmit register nor txEmptyN.
- R8: With ieWrEn high, ieSel selects which enable is written: 0 selects the receive enable and 1 selects the transmit enable. The enable takes the value ieVal at the clock edge.
- R9: irq is 1 exactly when rxFull is 1 with the receive enable set, or when txEmptyN is 1 with the transmit enable set.
- R10: While stbN is high, the receive register and cpuRdData hold their value whatever padIn does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe for the transmit register |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRdEn | input | 1 | CPU read strobe; acknowledges received data |
| cpuRdData | output | DATA_W | Receive register contents |
| ieWrEn | input | 1 | Interrupt-enable set/reset command |
| ieSel | input | 1 | Enable select: 0 receive, 1 transmit |
| ieVal | input | 1 | Value written to the selected enable |
| padIn | input | DATA_W | Data sensed on the shared pins |
| padOut | output | DATA_W | Data presented to the shared pins |
| padOe | output | DATA_W | Per-bit pin drive enable |
| stbN | input | 1 | Device strobe, low captures pins |
| ackN | input | 1 | Device acknowledge, low enables pin drive |
| rxFull | output | 1 | Receive buffer full |
| txEmptyN | output | 1 | Transmit buffer empty, low while data is pending |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions check the per-edge flag behaviour on every cycle. They cover strobe-sets-full, read-clears-full, write-clears-empty and acknowledge-sets-empty, including who wins a collision. They also check the pin release while ackN is high, that the receive data holds without a strobe, that the transmit register holds without a write, and that irq stays quiet when neither buffer calls for service. Only the bench scenarios can show the actual data values that pass each way, the enable selection by ieSel, and irq rising and falling as enables and flags change in sequence.

// File: rtl/bidir_hs_port_pkg.sv
package bidir_hs_port_pkg;

  // Strobes passed from the handshake control to the datapath
  typedef struct packed {
    logic captureRx;   // load receive register from the pins
    logic loadTx;      // load transmit register from the CPU
    logic drivePads;   // enable the pin drivers
  } hsStrobes_t;

  typedef enum logic {
    IE_SEL_RX = 1'b0,
    IE_SEL_TX = 1'b1
  } ieSel_e;

endpackage

// File: rtl/bidir_hs_port_ctrl.sv
module bidir_hs_port_ctrl
  import bidir_hs_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrEn,
  input  logic       cpuRdEn,
  input  logic       ieWrEn,
  input  logic       ieSel,
  input  logic       ieVal,
  input  logic       stbN,
  input  logic       ackN,
  output hsStrobes_t strobes,
  output logic       rxFull,
  output logic       txEmptyN,
  output logic       irq
);

  logic rxIe;
  logic txIe;

  always_comb begin
    strobes.captureRx = ~stbN;
    strobes.loadTx    = cpuWrEn;
    strobes.drivePads = ~ackN;
  end

  // Receive flag: a strobe outranks a CPU read on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)            rxFull <= 1'b0;
    else if (!stbN)       rxFull <= 1'b1;
    else if (cpuRdEn)     rxFull <= 1'b0;
  end

  // Transmit flag (low-true): a CPU write outranks an acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)            txEmptyN <= 1'b1;
    else if (cpuWrEn)     txEmptyN <= 1'b0;
    else if (!ackN)       txEmptyN <= 1'b1;
  end

  // Interrupt enables, bit set/reset style
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIe <= 1'b0;
      txIe <= 1'b0;
    end else if (ieWrEn) begin
      if (ieSel_e'(ieSel) == IE_SEL_RX) rxIe <= ieVal;
      else                              txIe <= ieVal;
    end
  end

  assign irq = (rxFull & rxIe) | (txEmptyN & txIe);

endmodule

// File: rtl/bidir_hs_port_dp.sv
module bidir_hs_port_dp
  import bidir_hs_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hsStrobes_t        strobes,
  input  logic [DATA_W-1:0] padIn,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] txReg;

  always_ff @(posedge clk) begin
    if (!rstN)                  rxReg <= ZERO;
    else if (strobes.captureRx) rxReg <= padIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               txReg <= ZERO;
    else if (strobes.loadTx) txReg <= cpuWrData;
  end

  assign cpuRdData = rxReg;
  assign padOut    = txReg;

  // One drive enable per pin
  for (genvar b = 0; b < DATA_W; b++) begin : g_oe
    assign padOe[b] = strobes.drivePads;
  end

endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
  import bidir_hs_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              ieWrEn,
  input  logic              ieSel,
  input  logic              ieVal,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic [DATA_W-1:0] padOe,
  input  logic              stbN,
  input  logic              ackN,
  output logic              rxFull,
  output logic              txEmptyN,
  output logic              irq
);

  hsStrobes_t strobes;

  bidir_hs_port_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuWrEn  (cpuWrEn),
    .cpuRdEn  (cpuRdEn),
    .ieWrEn   (ieWrEn),
    .ieSel    (ieSel),
    .ieVal    (ieVal),
    .stbN     (stbN),
    .ackN     (ackN),
    .strobes  (strobes),
    .rxFull   (rxFull),
    .txEmptyN (txEmptyN),
    .irq      (irq)
  );

  bidir_hs_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .padIn     (padIn),
    .cpuWrData (cpuWrData),
    .cpuRdData (cpuRdData),
    .padOut    (padOut),
    .padOe     (padOe)
  );

endmodule

// File: rtl/bidir_hs_port_chk.sv
module bidir_hs_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWrEn,
  input logic              cpuRdEn,
  input logic              stbN,
  input logic              ackN,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [DATA_W-1:0] padOut,
  input logic [DATA_W-1:0] padOe,
  input logic              rxFull,
  input logic              txEmptyN,
  input logic              irq
);

  // R2
  strobe_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stbN |=> rxFull);

  // R3
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && stbN) |=> !rxFull);

  // R4
  write_marks_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> !txEmptyN);

  // R5
  ack_marks_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !cpuWrEn) |=> txEmptyN);

  // R6
  pads_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackN |-> (padOe == '0));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWrEn |=> $stable(padOut));

  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbN |=> $stable(cpuRdData));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxFull && !txEmptyN) |-> !irq);

endmodule

bind bidir_hs_port bidir_hs_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWrEn   (cpuWrEn),
  .cpuRdEn   (cpuRdEn),
  .stbN      (stbN),
  .ackN      (ackN),
  .cpuRdData (cpuRdData),
  .padOut    (padOut),
  .padOe     (padOe),
  .rxFull    (rxFull),
  .txEmptyN  (txEmptyN),
  .irq       (irq)
);

// File: tb/bidir_hs_port_tb.sv
`timescale 1ns/1ps
module bidir_hs_port_tb;

  localparam int DW = 8;

  typedef enum int { S_RXFULL, S_TXEMPTYN, S_IRQ, S_OE, S_PADOUT, S_RDDATA } sig_e;
  typedef struct {
    string    req;
    sig_e     sel;
    logic [DW-1:0] exp;
  } item_t;

  logic clk = 0;
  logic rstN = 0;
  logic cpuWrEn = 0, cpuRdEn = 0, ieWrEn = 0, ieSel = 0, ieVal = 0;
  logic stbN = 1, ackN = 1;
  logic [DW-1:0] cpuWrData = '0, padIn = '0;
  logic [DW-1:0] cpuRdData, padOut, padOe;
  logic rxFull, txEmptyN, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t sb[$];

  always #5 clk = ~clk;

  bidir_hs_port #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData),
    .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData), .ieWrEn(ieWrEn), .ieSel(ieSel),
    .ieVal(ieVal), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .stbN(stbN), .ackN(ackN), .rxFull(rxFull), .txEmptyN(txEmptyN), .irq(irq)
  );

  task automatic expectv(string req, sig_e sel, logic [DW-1:0] v);
    item_t it;
    it.req = req; it.sel = sel; it.exp = v;
    sb.push_back(it);
  endtask

  // Drive values set at the preceding negedge across one rising edge
  task automatic tick();
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    cpuWrEn = 0; cpuRdEn = 0; ieWrEn = 0; stbN = 1; ackN = 1;
  endtask

  // Monitor: pops expectations 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [DW-1:0] act;
      it = sb.pop_front();
      case (it.sel)
        S_RXFULL:   act = {{(DW-1){1'b0}}, rxFull};
        S_TXEMPTYN: act = {{(DW-1){1'b0}}, txEmptyN};
        S_IRQ:      act = {{(DW-1){1'b0}}, irq};
        S_OE:       act = padOe;
        S_PADOUT:   act = padOut;
        default:    act = cpuRdData;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s %s actual=%h expected=%h", it.req, it.sel.name(), act, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    // R1 reset state
    expectv("R1", S_RXFULL, 8'h00);
    expectv("R1", S_TXEMPTYN, 8'h01);
    expectv("R1", S_IRQ, 8'h00);
    expectv("R1", S_OE, 8'h00);

    // R2 strobe captures pins
    @(negedge clk); padIn = 8'hA5; stbN = 0;
    tick();
    expectv("R2", S_RXFULL, 8'h01);
    expectv("R2", S_RDDATA, 8'hA5);
    // R10 pins change with strobe high
    idle(); padIn = 8'h3C;
    tick();
    expectv("R10", S_RDDATA, 8'hA5);
    expectv("R10", S_RXFULL, 8'h01);

    // R3 read clears full
    @(negedge clk); cpuRdEn = 1;
    tick();
    expectv("R3", S_RXFULL, 8'h00);
    expectv("R3", S_RDDATA, 8'hA5);
    // R3 strobe wins over read
    idle(); padIn = 8'h11; stbN = 0; cpuRdEn = 1;
    tick();
    expectv("R3", S_RXFULL, 8'h01);
    expectv("R2", S_RDDATA, 8'h11);
    idle(); cpuRdEn = 1;
    tick();
    expectv("R3", S_RXFULL, 8'h00);

    // R4 write marks pending
    idle(); cpuWrEn = 1; cpuWrData = 8'h5A;
    tick();
    expectv("R4", S_TXEMPTYN, 8'h00);
    expectv("R4", S_PADOUT, 8'h5A);
    expectv("R6", S_OE, 8'h00);

    // R7 read leaves transmit side alone
    idle(); cpuRdEn = 1;
    tick();
    expectv("R7", S_TXEMPTYN, 8'h00);
    expectv("R7", S_PADOUT, 8'h5A);

    // R5/R6 acknowledge drives pins and empties buffer
    idle(); ackN = 0;
    tick();
    expectv("R6", S_OE, 8'hFF);
    expectv("R6", S_PADOUT, 8'h5A);
    expectv("R5", S_TXEMPTYN, 8'h01);

    // R5 write wins over acknowledge
    idle(); ackN = 0; cpuWrEn = 1; cpuWrData = 8'hC3;
    tick();
    expectv("R5", S_TXEMPTYN, 8'h00);
    expectv("R4", S_PADOUT, 8'hC3);
    idle();
    tick();
    expectv("R6", S_OE, 8'h00);

    // R8/R9 receive enable
    idle(); ieWrEn = 1; ieSel = 0; ieVal = 1;
    tick();
    expectv("R9", S_IRQ, 8'h00);
    idle(); padIn = 8'h77; stbN = 0;
    tick();
    expectv("R9", S_IRQ, 8'h01);
    idle(); cpuRdEn = 1;
    tick();
    expectv("R9", S_IRQ, 8'h00);

    // R8 transmit enable with data pending
    idle(); ieWrEn = 1; ieSel = 1; ieVal = 1;
    tick();
    expectv("R8", S_IRQ, 8'h00);
    idle(); ackN = 0;
    tick();
    expectv("R9", S_IRQ, 8'h01);
    // R8 reset transmit enable
    idle(); ieWrEn = 1; ieSel = 1; ieVal = 0;
    tick();
    expectv("R8", S_IRQ, 8'h00);
    // R8 receive enable still set
    idle(); padIn = 8'h02; stbN = 0;
    tick();
    expectv("R8", S_IRQ, 8'h01);

    idle();
    repeat (2) @(posedge clk);
    #4;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule